// File: doc/BRIEF.md
# Ternary Weight Multiply Array

This block forms the partial products of a convolution layer whose weights take only the values -1, 0 and +1. Each cycle it takes one window of signed fixed-point activations per input channel and a 2-bit weight for every combination of output channel, input channel and kernel position. It then produces every product at once, across all three dimensions. A product is never formed by a multiplier. Each compute unit decodes its weight and then chooses zero, the activation, or the negated activation. The array therefore consists only of general logic and flip-flops.

The products leave the array registered, one cycle after the inputs are accepted, with a valid flag. They are meant to feed a downstream adder tree. The size of the array is fixed at build time by the maximum input channel count, output channel count and kernel edge length. There are `CIN*COUT*KSIZE*KSIZE` units in all.

Top module: `ternary_mul_array`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released with no valid input, `out_valid` is 0 and every product is 0. Reset takes precedence over a valid input.
- R2: A weight code of 2'b01 means +1. The product is the activation sign-extended to `ACT_W+1` bits.
- R3: A weight code of 2'b11 means -1. The product is the two's complement negation of the activation at `ACT_W+1` bits, so the most negative activation (-128 for 8 bits) gives +128 without overflow. No product ever equals -2^ACT_W.
- R4: A weight code of 2'b00 means 0. The product is zero whatever the activation.
- R5: The unused code 2'b10 gives a zero product, the same as code 2'b00.
- R6: Inputs sampled at a clock edge with `in_valid` high appear on `prod_out` after that same edge, and `out_valid` is 1 until the next edge. The latency is exactly one cycle.
- R7: At an edge where `in_valid` is low, `out_valid` goes to 0 and every product holds its previous value, whatever is on the activation and weight inputs.
- R8: Activation field `c*KK+k` occupies bits `ACT_W` wide starting at `(c*KK+k)*ACT_W`, where `KK=KSIZE*KSIZE`. Weight field and product field `u=(o*CIN+c)*KK+k` start at `2*u` and `u*(ACT_W+1)` respectively. Unit u combines only that weight with activation `(c,k)`, so one activation is shared across all output channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Activation and weight inputs are valid this cycle |
| act_in | input | CIN*KSIZE*KSIZE*ACT_W | Signed activations, one per input channel and kernel position |
| wgt_in | input | COUT*CIN*KSIZE*KSIZE*2 | Ternary weight codes, one per unit |
| out_valid | output | 1 | `prod_out` holds a fresh result |
| prod_out | output | COUT*CIN*KSIZE*KSIZE*(ACT_W+1) | Signed products, one per unit |

## Verification
The hardest case is proving that every unit gives the right result for every pairing of activation value and weight code. Each unit sees only its own slice of two wide buses, so a wrong field offset or a swapped channel could still look right under uniform stimulus. The stimulus offsets each position's activation by a stride of 37 from a shared step value and rotates each unit's code by its index. Over 256 steps and four rotation offsets, every unit therefore meets all 256 activations under all four codes, including -128 under code 2'b11. A directed pattern then enables exactly one unit, to expose any crossed wiring.

// File: rtl/tw_pkg.sv
package tw_pkg;

   // Raw 2-bit weight codes (two's complement of -1, 0, +1; 2'b10 unused)
   typedef enum logic [1:0] {
      TW_ZERO = 2'b00,
      TW_POS  = 2'b01,
      TW_RSV  = 2'b10,
      TW_NEG  = 2'b11
   } tw_code_e;

   // Decoded mux selection driven into each unit
   typedef enum logic [1:0] {
      SEL_ZERO = 2'b00,
      SEL_PASS = 2'b01,
      SEL_INV  = 2'b10
   } tw_sel_e;

   function automatic tw_sel_e tw_decode_fn(input logic [1:0] code);
      tw_sel_e s;
      case (tw_code_e'(code))
         TW_POS:  s = SEL_PASS;
         TW_NEG:  s = SEL_INV;
         default: s = SEL_ZERO;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/tw_decode.sv
module tw_decode
   import tw_pkg::*;
(
   input  logic [1:0] code,
   output tw_sel_e    sel
);

   always_comb begin
      sel = tw_decode_fn(code);
   end

endmodule

// File: rtl/tw_unit.sv
module tw_unit
   import tw_pkg::*;
#(
   parameter int ACT_W    = 8,
   parameter int NEG_MODE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [ACT_W-1:0]   act,
   input  logic [1:0]         code,
   output logic [ACT_W:0]     prod
);

   localparam int PROD_W = ACT_W + 1;

   tw_sel_e           sel;
   logic [PROD_W-1:0] ext;
   logic [PROD_W-1:0] neg;
   logic [PROD_W-1:0] nxt;

   tw_decode u_dec (
      .code (code),
      .sel  (sel)
   );

   assign ext = {act[ACT_W-1], act};

   generate
      if (NEG_MODE == 0) begin : g_neg_sub
         assign neg = PROD_W'(0) - ext;
      end else begin : g_neg_inv
         assign neg = (~ext) + PROD_W'(1);
      end
   endgenerate

   always_comb begin
      case (sel)
         SEL_PASS: nxt = ext;
         SEL_INV:  nxt = neg;
         default:  nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  prod <= '0;
      else if (en) prod <= nxt;
   end

   // R2
   pos_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(en) && $past(code) == 2'b01)
         |-> prod == {$past(act[ACT_W-1]), $past(act)});

   // R3
   neg_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(en) && $past(code) == 2'b11)
         |-> (prod + {$past(act[ACT_W-1]), $past(act)}) == PROD_W'(0));

   // R4 and R5
   zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(en) && $past(code[0]) == 1'b0) |-> prod == '0);

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(en)) |-> $stable(prod));

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prod != {1'b1, {ACT_W{1'b0}}});

endmodule

// File: rtl/ternary_mul_array.sv
module ternary_mul_array #(
   parameter int ACT_W    = 8,
   parameter int CIN      = 2,
   parameter int COUT     = 2,
   parameter int KSIZE    = 3,
   parameter int NEG_MODE = 0
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       in_valid,
   input  logic [CIN*KSIZE*KSIZE*ACT_W-1:0]           act_in,
   input  logic [COUT*CIN*KSIZE*KSIZE*2-1:0]          wgt_in,
   output logic                                       out_valid,
   output logic [COUT*CIN*KSIZE*KSIZE*(ACT_W+1)-1:0]  prod_out
);

   localparam int KK     = KSIZE * KSIZE;
   localparam int PROD_W = ACT_W + 1;
   localparam int NUNIT  = COUT * CIN * KK;

   generate
      if (ACT_W < 2) begin : g_bad_actw
         $error("ternary_mul_array: ACT_W must be at least 2");
      end
      if (CIN < 1 || COUT < 1 || KSIZE < 1) begin : g_bad_dims
         $error("ternary_mul_array: channel counts and kernel size must be positive");
      end
      if (NEG_MODE != 0 && NEG_MODE != 1) begin : g_bad_neg
         $error("ternary_mul_array: NEG_MODE must be 0 or 1");
      end
      if (NUNIT > 4096) begin : g_bad_size
         $error("ternary_mul_array: array too large");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   generate
      for (genvar o = 0; o < COUT; o++) begin : g_oc
         for (genvar c = 0; c < CIN; c++) begin : g_ic
            for (genvar k = 0; k < KK; k++) begin : g_kp
               localparam int U = (o * CIN + c) * KK + k;
               localparam int A = c * KK + k;
               tw_unit #(
                  .ACT_W    (ACT_W),
                  .NEG_MODE (NEG_MODE)
               ) u_unit (
                  .clk  (clk),
                  .rst_n(rst_n),
                  .en   (in_valid),
                  .act  (act_in[A*ACT_W +: ACT_W]),
                  .code (wgt_in[U*2 +: 2]),
                  .prod (prod_out[U*PROD_W +: PROD_W])
               );
            end
         end
      end
   endgenerate

   // R6
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid));

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rst_n) && !out_valid) |-> prod_out == '0);

endmodule

// File: tb/sim_ternary_mul_array.sv
`timescale 1ns/1ps
module sim_ternary_mul_array;

   localparam int ACT_W = 8;
   localparam int CIN   = 2;
   localparam int COUT  = 2;
   localparam int KSIZE = 3;
   localparam int KK    = KSIZE * KSIZE;
   localparam int NACT  = CIN * KK;
   localparam int NUNIT = COUT * CIN * KK;
   localparam int PW    = ACT_W + 1;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     in_valid = 1'b0;
   logic [NACT*ACT_W-1:0]    act_in = '0;
   logic [NUNIT*2-1:0]       wgt_in = '0;
   logic                     out_valid;
   logic [NUNIT*PW-1:0]      prod_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [PW-1:0] exp_q [NUNIT];

   always #2.5 clk = ~clk;

   ternary_mul_array #(
      .ACT_W(ACT_W), .CIN(CIN), .COUT(COUT), .KSIZE(KSIZE), .NEG_MODE(0)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .act_in(act_in), .wgt_in(wgt_in),
      .out_valid(out_valid), .prod_out(prod_out)
   );

   function automatic logic [PW-1:0] model(input logic [7:0] a, input logic [1:0] w);
      int v;
      v = int'($signed(a));
      if (w == 2'b01) return PW'(v);
      if (w == 2'b11) return PW'(-v);
      return '0;
   endfunction

   function automatic string tag_of(input logic [1:0] w);
      case (w)
         2'b01:   return "R2";
         2'b11:   return "R3";
         2'b00:   return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic cmp(input string req, input int got, input int expv);
      n_cmp++;
      if (got != expv) begin
         n_bad++;
         $display("FAIL %s got=%0d expected=%0d at %0t", req, got, expv, $time);
      end
   endtask

   task automatic check_all(input string req);
      for (int u = 0; u < NUNIT; u++)
         cmp(req, int'(prod_out[u*PW +: PW]), int'(exp_q[u]));
   endtask

   initial begin
      // R1: reset dominates a valid input
      for (int u = 0; u < NUNIT; u++) exp_q[u] = '0;
      in_valid = 1'b1;
      act_in   = {NACT{8'h5A}};
      wgt_in   = {NUNIT{2'b01}};
      repeat (3) @(negedge clk);
      cmp("R1", int'(out_valid), 0);
      check_all("R1");
      in_valid = 1'b0;
      rst_n    = 1'b1;
      @(negedge clk);
      cmp("R1", int'(out_valid), 0);
      check_all("R1");

      // R2..R6, R8: every unit meets every activation under every code
      for (int off = 0; off < 4; off++) begin
         for (int step = 0; step < 256; step++) begin
            logic [1:0] wv [NUNIT];
            logic [7:0] av [NACT];
            in_valid = 1'b1;
            for (int i = 0; i < NACT; i++) begin
               av[i] = 8'((step + i * 37) & 255);
               act_in[i*ACT_W +: ACT_W] = av[i];
            end
            for (int o = 0; o < COUT; o++)
               for (int c = 0; c < CIN; c++)
                  for (int k = 0; k < KK; k++) begin
                     int u;
                     u = (o * CIN + c) * KK + k;
                     wv[u] = 2'((u + off + step) & 3);
                     wgt_in[u*2 +: 2] = wv[u];
                     exp_q[u] = model(av[c*KK+k], wv[u]);
                  end
            @(negedge clk);
            cmp("R6", int'(out_valid), 1);
            for (int u = 0; u < NUNIT; u++)
               cmp(tag_of(wv[u]), int'(prod_out[u*PW +: PW]), int'(exp_q[u]));
         end
      end

      // R7: inputs change with in_valid low; products hold, out_valid drops
      in_valid = 1'b0;
      act_in   = {NACT{8'h81}};
      wgt_in   = {NUNIT{2'b11}};
      @(negedge clk);
      cmp("R7", int'(out_valid), 0);
      check_all("R7");
      act_in = {NACT{8'h7F}};
      wgt_in = {NUNIT{2'b01}};
      @(negedge clk);
      cmp("R7", int'(out_valid), 0);
      check_all("R7");

      // R8: a single enabled unit exposes any crossed field
      in_valid = 1'b1;
      for (int i = 0; i < NACT; i++) act_in[i*ACT_W +: ACT_W] = 8'(i + 1);
      wgt_in = '0;
      wgt_in[((1 * CIN + 1) * KK + 4)*2 +: 2] = 2'b01;
      for (int u = 0; u < NUNIT; u++) exp_q[u] = '0;
      exp_q[(1 * CIN + 1) * KK + 4] = PW'(KK + 4 + 1);
      @(negedge clk);
      cmp("R8", int'(out_valid), 1);
      check_all("R8");

      // R3: most negative activation under -1 everywhere
      act_in = {NACT{8'h80}};
      wgt_in = {NUNIT{2'b11}};
      for (int u = 0; u < NUNIT; u++) exp_q[u] = PW'(128);
      @(negedge clk);
      check_all("R3");

      in_valid = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog got=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule